// File: doc/BRIEF.md
# Single-Channel Block Copy Engine

The block moves a contiguous run of 32-bit words between an external memory and a private 4096-byte scratch buffer held inside the block. Software programs a source address, a destination address and a byte count through a small 64-bit register bus. It then writes a command word. One command bit picks the direction of the copy. On the buffer side, the address must fall in a fixed window of the device space that starts at 0x40000 and is 4096 bytes long.

External memory is reached through a word-wide port. It has a request channel with a valid/ready handshake and a response channel that carries read data with a valid strobe. Exactly one word moves per handshake. When a copy finishes, the engine can optionally latch a completion flag. That flag drives the interrupt line until software acknowledges it. If a request would run past the end of the buffer window, the engine finishes it at once and moves no data.

Top module: `blk_dma_engine`

## Requirements
- R1: After reset the source, destination, count, command and interrupt-status registers all read 0, `irq` is low and no memory request is issued.
- R2: The source (offset 0x80), destination (0x88) and count (0x90) registers read back all 64 written bits. The command register (0x98) reads bit 0 as the running flag, bit 1 as the direction and bit 2 as the interrupt enable.
- R3: Writing the command register with bit 0 set while idle starts a copy. Bit 0 then reads 1 until the copy ends and returns to 0 on its own.
- R4: With direction bit 1 clear, the engine issues count/4 reads at source, source+4, and so on upward. Each returned word is stored in the buffer at word offset (destination − 0x40000)/4 onward.
- R5: With direction bit 1 set, the engine issues count/4 writes at destination, destination+4, and so on upward. The data comes from the buffer starting at word offset (source − 0x40000)/4.
- R6: A 2048-byte block copied into the buffer and then copied back out to a different external address arrives bit-identical.
- R7: When command bit 2 was set, completion sets bit 8 (value 0x100) of the interrupt-status register at offset 0x98+8 = 0xA0. `irq` is high while that bit is set. Writing 1 to bit 8 of 0xA0 clears it. With bit 2 clear, completion leaves the bit at 0.
- R8: Writes to offsets 0x80, 0x88, 0x90 and 0x98 are ignored while a copy runs.
- R9: If the buffer-side address lies outside [0x40000, 0x41000), or if offset plus count exceeds 4096, the copy is rejected. The engine issues no memory request. Bit 0 reads 1 for exactly one cycle after the command write, and the interrupt flag is still raised when bit 2 is set.
- R10: A count of 0 behaves like R9: no request, a single busy cycle, and the interrupt flag set when bit 2 is set.
- R11: Once `mem_req_valid` rises, it stays high with address, write flag and write data unchanged until `mem_req_ready` is sampled high.
- R12: Memory requests appear only while a copy runs, and their write flag always equals the direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Register read data, combinational from `cfg_addr` |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | 64 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| irq | output | 1 | Completion interrupt, level |

## Verification
Register reads are combinational, so the bench samples them in the same cycle it sets the offset. A command write takes effect at the clock edge that captures it. For rejected and zero-length copies, the running flag is due high in the cycle after that edge and low one edge later, with the status bit already set. The bench samples in exactly those two cycles. Memory requests are due at no fixed cycle, because the bench memory stalls and delays responses. The reference model therefore holds a queue of expected requests, built when the copy starts. On every clock, the model compares each accepted handshake against the head of that queue and flags any request it did not predict.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam logic [7:0] OFS_SRC  = 8'h80;
  localparam logic [7:0] OFS_DST  = 8'h88;
  localparam logic [7:0] OFS_CNT  = 8'h90;
  localparam logic [7:0] OFS_CMD  = 8'h98;
  localparam logic [7:0] OFS_STAT = 8'hA0;

  localparam int CMD_RUN_BIT = 0;
  localparam int CMD_DIR_BIT = 1;
  localparam int CMD_IEN_BIT = 2;
  localparam int STAT_DONE_BIT = 8;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RREQ,
    SQ_RWAIT,
    SQ_BRD,
    SQ_WREQ,
    SQ_FIN
  } seq_state_e;
endpackage

// File: rtl/dma_buf_ram.sv
module dma_buf_ram #(
  parameter int WORDS = 1024,
  parameter int DW    = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int RW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_addr,
  input  logic [RW-1:0] cfg_wdata,
  output logic [RW-1:0] cfg_rdata,
  input  logic          xfer_done,
  output logic [RW-1:0] src_q,
  output logic [RW-1:0] dst_q,
  output logic [RW-1:0] cnt_q,
  output logic          dir_q,
  output logic          ien_q,
  output logic          busy_q,
  output logic          start,
  output logic          int_q
);
  logic wr_src, wr_dst, wr_cnt, wr_cmd, wr_stat;
  logic busy_d, int_d, busy_en, int_en;

  always_comb begin
    wr_src  = cfg_we && (cfg_addr == OFS_SRC) && !busy_q;
    wr_dst  = cfg_we && (cfg_addr == OFS_DST) && !busy_q;
    wr_cnt  = cfg_we && (cfg_addr == OFS_CNT) && !busy_q;
    wr_cmd  = cfg_we && (cfg_addr == OFS_CMD) && !busy_q;
    wr_stat = cfg_we && (cfg_addr == OFS_STAT);
    start   = wr_cmd && cfg_wdata[CMD_RUN_BIT];
  end

  always_comb begin
    busy_d  = busy_q;
    busy_en = 1'b0;
    if (start) begin
      busy_d  = 1'b1;
      busy_en = 1'b1;
    end else if (xfer_done) begin
      busy_d  = 1'b0;
      busy_en = 1'b1;
    end
    int_d  = int_q;
    int_en = 1'b0;
    if (xfer_done && ien_q) begin
      int_d  = 1'b1;
      int_en = 1'b1;
    end else if (wr_stat && cfg_wdata[STAT_DONE_BIT]) begin
      int_d  = 1'b0;
      int_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else if (wr_src) src_q <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dst_q <= '0;
    else if (wr_dst) dst_q <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (wr_cnt) cnt_q <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      ien_q <= 1'b0;
    end else if (wr_cmd) begin
      dir_q <= cfg_wdata[CMD_DIR_BIT];
      ien_q <= cfg_wdata[CMD_IEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else if (busy_en) busy_q <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_q <= 1'b0;
    else if (int_en) int_q <= int_d;
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_addr)
      OFS_SRC:  cfg_rdata = src_q;
      OFS_DST:  cfg_rdata = dst_q;
      OFS_CNT:  cfg_rdata = cnt_q;
      OFS_CMD: begin
        cfg_rdata[CMD_RUN_BIT] = busy_q;
        cfg_rdata[CMD_DIR_BIT] = dir_q;
        cfg_rdata[CMD_IEN_BIT] = ien_q;
      end
      OFS_STAT: cfg_rdata[STAT_DONE_BIT] = int_q;
      default:  cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int          RW        = 64,
  parameter int          DW        = 32,
  parameter int          BUF_BYTES = 4096,
  parameter logic [63:0] WIN_BASE  = 64'h0000_0000_0004_0000,
  localparam int WORDS = BUF_BYTES / (DW / 8),
  localparam int IW    = $clog2(WORDS),
  localparam int OFW   = $clog2(BUF_BYTES),
  localparam int CW    = IW + 1,
  localparam int SH    = $clog2(DW / 8)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir,
  input  logic [RW-1:0] src,
  input  logic [RW-1:0] dst,
  input  logic [RW-1:0] cnt,
  output logic          done,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [RW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata,
  output logic          ram_we,
  output logic [IW-1:0] ram_waddr,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_re,
  output logic [IW-1:0] ram_raddr,
  input  logic [DW-1:0] ram_rdata
);
  seq_state_e    st_q, st_d;
  logic [RW-1:0] ext_q, ext_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [CW-1:0] left_q, left_d;
  logic          ptr_en;

  logic [RW-1:0]  buf_addr;
  logic           in_win;
  logic [OFW-1:0] buf_off;
  logic [RW:0]    span_end;
  logic           accept;

  always_comb begin
    buf_addr = dir ? src : dst;
    in_win   = (buf_addr >= WIN_BASE) && (buf_addr < (WIN_BASE + 64'(BUF_BYTES)));
    buf_off  = buf_addr[OFW-1:0] - WIN_BASE[OFW-1:0];
    span_end = {1'b0, cnt} + (RW+1)'(buf_off);
    accept   = in_win && (span_end <= (RW+1)'(BUF_BYTES)) && (cnt != '0);
  end

  always_comb begin
    st_d   = st_q;
    ext_d  = ext_q;
    idx_d  = idx_q;
    left_d = left_q;
    ptr_en = 1'b0;
    ram_we = 1'b0;
    ram_re = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (start) begin
          if (accept) begin
            ptr_en = 1'b1;
            ext_d  = dir ? dst : src;
            idx_d  = buf_off[OFW-1:SH];
            left_d = cnt[CW+SH-1:SH];
            st_d   = dir ? SQ_BRD : SQ_RREQ;
          end else begin
            st_d = SQ_FIN;
          end
        end
      end
      SQ_RREQ: begin
        if (mem_req_ready) st_d = SQ_RWAIT;
      end
      SQ_RWAIT: begin
        if (mem_rsp_valid) begin
          ram_we = 1'b1;
          ptr_en = 1'b1;
          ext_d  = ext_q + RW'(DW / 8);
          idx_d  = idx_q + 1'b1;
          left_d = left_q - 1'b1;
          st_d   = (left_q == CW'(1)) ? SQ_FIN : SQ_RREQ;
        end
      end
      SQ_BRD: begin
        ram_re = 1'b1;
        st_d   = SQ_WREQ;
      end
      SQ_WREQ: begin
        if (mem_req_ready) begin
          ptr_en = 1'b1;
          ext_d  = ext_q + RW'(DW / 8);
          idx_d  = idx_q + 1'b1;
          left_d = left_q - 1'b1;
          st_d   = (left_q == CW'(1)) ? SQ_FIN : SQ_BRD;
        end
      end
      SQ_FIN:  st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= '0;
      idx_q  <= '0;
      left_q <= '0;
    end else if (ptr_en) begin
      ext_q  <= ext_d;
      idx_q  <= idx_d;
      left_q <= left_d;
    end
  end

  always_comb begin
    done          = (st_q == SQ_FIN);
    mem_req_valid = (st_q == SQ_RREQ) || (st_q == SQ_WREQ);
    mem_req_write = (st_q == SQ_WREQ);
    mem_req_addr  = ext_q;
    mem_req_wdata = ram_rdata;
    ram_waddr     = idx_q;
    ram_raddr     = idx_q;
    ram_wdata     = mem_rsp_rdata;
  end
endmodule

// File: rtl/blk_dma_engine.sv
module blk_dma_engine #(
  parameter int          RW        = 64,
  parameter int          DW        = 32,
  parameter int          BUF_BYTES = 4096,
  parameter logic [63:0] WIN_BASE  = 64'h0000_0000_0004_0000,
  localparam int WORDS = BUF_BYTES / (DW / 8),
  localparam int IW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_addr,
  input  logic [RW-1:0] cfg_wdata,
  output logic [RW-1:0] cfg_rdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [RW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata,
  output logic          irq
);
  logic [1:0]    rst_sync_q;
  logic          rst_q_n;
  logic [RW-1:0] src_w, dst_w, cnt_w;
  logic          dir_w, ien_w, busy_w, start_w, done_w, int_w;
  logic          ram_we, ram_re;
  logic [IW-1:0] ram_waddr, ram_raddr;
  logic [DW-1:0] ram_wdata, ram_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  dma_regs #(.RW(RW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .xfer_done(done_w),
    .src_q    (src_w),
    .dst_q    (dst_w),
    .cnt_q    (cnt_w),
    .dir_q    (dir_w),
    .ien_q    (ien_w),
    .busy_q   (busy_w),
    .start    (start_w),
    .int_q    (int_w)
  );

  dma_seq #(
    .RW(RW), .DW(DW), .BUF_BYTES(BUF_BYTES), .WIN_BASE(WIN_BASE)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .start        (start_w),
    .dir          (dir_w_next()),
    .src          (src_w),
    .dst          (dst_w),
    .cnt          (cnt_w),
    .done         (done_w),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write),
    .mem_req_addr (mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata),
    .ram_we       (ram_we),
    .ram_waddr    (ram_waddr),
    .ram_wdata    (ram_wdata),
    .ram_re       (ram_re),
    .ram_raddr    (ram_raddr),
    .ram_rdata    (ram_rdata)
  );

  function automatic logic dir_w_next();
    return start_w ? cfg_wdata[dma_pkg::CMD_DIR_BIT] : dir_w;
  endfunction

  dma_buf_ram #(.WORDS(WORDS), .DW(DW)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .re   (ram_re),
    .raddr(ram_raddr),
    .rdata(ram_rdata)
  );

  assign irq = int_w;
endmodule

module blk_dma_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic busy_w,
  input logic dir_w,
  input logic ien_w,
  input logic done_w,
  input logic irq,
  input logic mem_req_valid,
  input logic mem_req_ready,
  input logic mem_req_write,
  input logic [63:0] mem_req_addr,
  input logic [31:0] mem_req_wdata
);
  a_r12_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy_w);

  a_r12_write_matches_dir: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_write == dir_w));

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata)));

  a_r3_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |=> !busy_w);

  a_r7_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($fell(busy_w) && $past(ien_w)));
endmodule

bind blk_dma_engine blk_dma_engine_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_w       (busy_w),
  .dir_w        (dir_w),
  .ien_w        (ien_w),
  .done_w       (done_w),
  .irq          (irq),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write),
  .mem_req_addr (mem_req_addr),
  .mem_req_wdata(mem_req_wdata)
);

// File: tb/blk_dma_engine_tb_top.sv
module blk_dma_engine_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [63:0] cfg_wdata;
  logic [63:0] cfg_rdata;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [63:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;
  logic        irq;

  blk_dma_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .irq(irq)
  );

  localparam logic [7:0] A_SRC = 8'h80, A_DST = 8'h88, A_CNT = 8'h90,
                         A_CMD = 8'h98, A_STAT = 8'hA0;
  localparam longint WBASE = 64'h40000;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int cyc = 0;

  typedef struct { bit wr; logic [63:0] addr; logic [31:0] data; } req_t;
  typedef struct { logic [31:0] data; int due; } rsp_t;
  req_t expq[$];
  rsp_t pend[$];
  logic [31:0] xmem [longint];
  logic [31:0] mbuf [0:1023];

  function automatic logic [31:0] ext_rd(logic [63:0] a);
    if (xmem.exists(a)) return xmem[a];
    return a[31:0] ^ 32'hA5A5_0000;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  // External memory model and per-clock request comparison
  initial begin
    logic [7:0] lfsr;
    lfsr = 8'h5B;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
    forever begin
      @(negedge clk);
      cyc++;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_req_ready = lfsr[0] | lfsr[1];
      if (pend.size() > 0 && pend[0].due <= cyc) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = pend[0].data;
        void'(pend.pop_front());
      end else begin
        mem_rsp_valid = 1'b0;
      end
      #1;
      if (rst_n && mem_req_valid) begin
        if (expq.size() == 0) begin
          check(1'b0, "R9/R10 unexpected request", mem_req_addr, 64'h0);
        end else if (mem_req_ready) begin
          req_t e;
          e = expq.pop_front();
          if (e.wr) begin
            check(mem_req_write && mem_req_addr == e.addr && mem_req_wdata == e.data,
                  "R5 write request", {mem_req_addr[31:0], mem_req_wdata},
                  {e.addr[31:0], e.data});
            xmem[mem_req_addr] = mem_req_wdata;
          end else begin
            check(!mem_req_write && mem_req_addr == e.addr, "R4 read request",
                  mem_req_addr, e.addr);
            pend.push_back('{data: ext_rd(mem_req_addr), due: cyc + 1 + int'(lfsr[2])});
          end
        end
      end
    end
  end

  task automatic cfg_write(logic [7:0] a, logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(logic [7:0] a, output logic [63:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  // Build the expected request list and buffer contents, then launch.
  task automatic launch(logic [63:0] s, logic [63:0] d, logic [63:0] c, bit dir, bit ien);
    logic [63:0] ba;
    bit ok;
    ba = dir ? s : d;
    ok = (ba >= WBASE) && (ba < WBASE + 4096) && ((ba - WBASE) + c <= 4096) && (c != 0);
    if (ok) begin
      for (int i = 0; i < int'(c / 4); i++) begin
        int bi;
        bi = int'((ba - WBASE) / 4) + i;
        if (!dir) begin
          expq.push_back('{wr: 1'b0, addr: s + 64'(4 * i), data: 32'h0});
          mbuf[bi] = ext_rd(s + 64'(4 * i));
        end else begin
          expq.push_back('{wr: 1'b1, addr: d + 64'(4 * i), data: mbuf[bi]});
        end
      end
    end
    cfg_write(A_SRC, s);
    cfg_write(A_DST, d);
    cfg_write(A_CNT, c);
    cfg_write(A_CMD, {61'b0, ien, dir, 1'b1});
  endtask

  task automatic wait_idle();
    logic [63:0] v;
    do begin
      @(negedge clk);
      cfg_read(A_CMD, v);
    end while (v[0]);
  endtask

  initial begin
    logic [63:0] v;
    logic [31:0] x;
    int bad;
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    cfg_read(A_SRC, v);  check(v == 0, "R1 src reset", v, 0);
    cfg_read(A_DST, v);  check(v == 0, "R1 dst reset", v, 0);
    cfg_read(A_CNT, v);  check(v == 0, "R1 cnt reset", v, 0);
    cfg_read(A_CMD, v);  check(v == 0, "R1 cmd reset", v, 0);
    cfg_read(A_STAT, v); check(v == 0, "R1 stat reset", v, 0);
    check(irq == 0 && mem_req_valid == 0, "R1 outputs idle", {irq, mem_req_valid}, 0);

    // R2 readback
    cfg_write(A_SRC, 64'h1122_3344_5566_7788);
    cfg_write(A_DST, 64'hFEDC_BA98_7654_3210);
    cfg_write(A_CNT, 64'h8000_0000_0000_0ABC);
    cfg_read(A_SRC, v); check(v == 64'h1122_3344_5566_7788, "R2 src", v, 64'h1122_3344_5566_7788);
    cfg_read(A_DST, v); check(v == 64'hFEDC_BA98_7654_3210, "R2 dst", v, 64'hFEDC_BA98_7654_3210);
    cfg_read(A_CNT, v); check(v == 64'h8000_0000_0000_0ABC, "R2 cnt", v, 64'h8000_0000_0000_0ABC);

    // Fill source block with xorshift data
    x = 32'h1122_3344;
    for (int i = 0; i < 512; i++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      xmem[64'h1000_0000 + 64'(4 * i)] = x;
    end

    // R4 external to buffer, interrupt enabled
    launch(64'h1000_0000, WBASE, 2048, 1'b0, 1'b1);
    cfg_read(A_CMD, v); check(v[0] == 1 && v[1] == 0 && v[2] == 1, "R3 running flag", v, 64'h5);
    // R8 writes ignored while busy
    cfg_write(A_SRC, 64'hDEAD);
    cfg_write(A_CMD, 64'h3);
    cfg_read(A_SRC, v); check(v == 64'h1000_0000, "R8 src ignored", v, 64'h1000_0000);
    cfg_read(A_CMD, v); check(v[1] == 0, "R8 cmd ignored", v, 64'h5);
    wait_idle();
    check(expq.size() == 0, "R4 all reads issued", expq.size(), 0);
    cfg_read(A_CMD, v); check(v[0] == 0, "R3 flag auto clears", v, 64'h4);
    cfg_read(A_STAT, v); check(v == 64'h100, "R7 status set", v, 64'h100);
    check(irq == 1, "R7 irq high", irq, 1);
    cfg_write(A_STAT, 64'h100);
    cfg_read(A_STAT, v); check(v == 0, "R7 status cleared", v, 0);
    check(irq == 0, "R7 irq cleared", irq, 0);

    // R5 buffer to external, no interrupt
    launch(WBASE, 64'h2000_0000, 2048, 1'b1, 1'b0);
    wait_idle();
    check(expq.size() == 0, "R5 all writes issued", expq.size(), 0);
    cfg_read(A_STAT, v); check(v == 0 && irq == 0, "R7 no irq without enable", v, 0);
    bad = 0;
    for (int i = 0; i < 512; i++)
      if (ext_rd(64'h2000_0000 + 64'(4 * i)) !== ext_rd(64'h1000_0000 + 64'(4 * i))) bad++;
    check(bad == 0, "R6 round trip identical", bad, 0);

    // R4/R5 with a non-zero buffer offset
    launch(64'h3000_0000, WBASE + 64'h810, 64, 1'b0, 1'b0);
    wait_idle();
    launch(WBASE + 64'h810, 64'h5000_0000, 64, 1'b1, 1'b0);
    wait_idle();
    check(expq.size() == 0, "R5 offset copy complete", expq.size(), 0);

    // R9 rejected: range runs past the window end
    cfg_write(A_SRC, 64'h6000_0000);
    cfg_write(A_DST, WBASE + 64'hF00);
    cfg_write(A_CNT, 64'h200);
    cfg_write(A_CMD, 64'h5);
    cfg_read(A_CMD, v); check(v[0] == 1, "R9 busy one cycle", v, 64'h5);
    @(negedge clk);
    cfg_read(A_CMD, v); check(v[0] == 0, "R9 busy cleared next cycle", v, 64'h4);
    check(irq == 1, "R9 irq on reject", irq, 1);
    cfg_write(A_STAT, 64'h100);

    // R9 rejected: buffer side outside the window
    launch(WBASE - 4, 64'h7000_0000, 16, 1'b1, 1'b0);
    cfg_read(A_CMD, v); check(v[0] == 1, "R9 outside window busy", v, 64'h3);
    @(negedge clk);
    cfg_read(A_CMD, v); check(v[0] == 0, "R9 outside window done", v, 64'h2);
    check(irq == 0, "R9 no irq when disabled", irq, 0);

    // R10 zero count
    launch(64'h8000_0000, WBASE, 0, 1'b0, 1'b1);
    cfg_read(A_CMD, v); check(v[0] == 1, "R10 busy one cycle", v, 64'h5);
    @(negedge clk);
    cfg_read(A_CMD, v); check(v[0] == 0, "R10 busy cleared", v, 64'h4);
    cfg_read(A_STAT, v); check(v == 64'h100, "R10 irq status", v, 64'h100);

    repeat (10) @(negedge clk);
    check(expq.size() == 0, "R12 no stray requests", expq.size(), 0);
    finish_run();
  end
endmodule